// File: doc/BRIEF.md
# Selectable-Overflow SCL Clock Generator

This block produces the clock line of a two-wire serial bus master (SMBus or I2C) from pulses that timers elsewhere in the chip already make. It does not divide the system clock itself. Four overflow strobes come in, and a two-bit select field chooses one of them. While the master is active, the generator pulls SCL low for two selected pulses and then releases it for one. If no other device stretches the clock, the bit rate is the overflow rate divided by three. After releasing SCL, the generator does not start timing the high phase until it samples the line high. A slave or a competing master holding the line low therefore lengthens the bit instead of corrupting it. Each SCL edge the master makes produces a one-cycle strobe that the shift logic can use: one on the rising edge for sampling and one on the falling edge for changing data.

The block also holds the global enable and the slave-inhibit control for the interface. An inhibit request is latched only when a START condition is detected, so a transfer already in progress keeps its slave events. While inhibit is in force, the address logic is told to NACK every address, and slave events are reported as disallowed. The timers are only observed and are never stopped or reloaded, so they can be shared with other peripherals. The gated selected pulse is also provided for free-bus timeout logic outside this block.

Top module: `smb_scl_timer`

## Requirements
- R1: `src_sel` picks the overflow input by index: 0 picks `ovf_i[0]`, 1 picks `ovf_i[1]`, 2 picks `ovf_i[2]` and 3 picks `ovf_i[3]`. Whenever the gate is open, `tmr_tick` equals the selected input in the same cycle.
- R2: The gate is open only while `bus_en` is set and at least one of `mst_req` or `tmo_en` is set. With `mst_req` and `tmo_en` both clear, `tmr_tick` stays 0 and SCL is never driven, whatever the overflow inputs do.
- R3: Once SCL is driven low, it is released at the clock edge that samples the second selected pulse. The low phase therefore lasts exactly 2 overflow periods.
- R4: With no stretching, the time from one falling SCL edge to the next is exactly 3 overflow periods.
- R5: `bit_tick` is a one-cycle strobe. It is high in the cycle in which `scl_drive_low` first shows 1 (falling edge), and in the cycle after the released line is first sampled high (rising edge). Exactly two strobes occur per bit.
- R6: While `bus_en` is clear, `scl_drive_low`, `bit_tick`, `tmr_tick`, `slave_en` and `force_nack` are all 0.
- R7: While the bus is enabled, a change of `slv_inhibit` does not alter `slave_en` or `force_nack` until `start_det` has been sampled high. The new value shows from the following cycle, and this applies both to setting and to clearing the inhibit.
- R8: With the inhibit in force and the bus enabled, `force_nack` is 1 and `slave_en` is 0. Without the inhibit, `force_nack` is 0 and `slave_en` is 1.
- R9: While SCL is released and sampled low (stretched), selected pulses are ignored and SCL stays released. The high phase is counted from the first cycle the line is seen high, and SCL is driven low again within one overflow period after that.
- R10: When `mst_req` is sampled low, SCL is released from the next cycle on.
- R11: During and after reset, SCL is released and `bit_tick` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ovf_i | input | 4 | Timer overflow strobes, one cycle each |
| src_sel | input | 2 | Index of the overflow strobe used for timing |
| bus_en | input | 1 | Global interface enable |
| slv_inhibit | input | 1 | Request to inhibit slave events |
| mst_req | input | 1 | Master transfer active, clock generation wanted |
| tmo_en | input | 1 | Free-bus timeout detection enabled |
| scl_in | input | 1 | Sampled SCL line level |
| start_det | input | 1 | START condition detected strobe |
| scl_drive_low | output | 1 | Open-drain SCL pull-down (1 pulls low) |
| bit_tick | output | 1 | Strobe on each master SCL edge |
| tmr_tick | output | 1 | Gated selected overflow strobe |
| slave_en | output | 1 | Slave events allowed |
| force_nack | output | 1 | NACK every received address |

## Verification
The assertions assume that overflow strobes and `start_det` are synchronous single-cycle pulses. They also assume that `scl_in` goes high only when the master itself has released the line. The bench models the wire as the AND of the master's release and a separate stretch flag, so the line is never high while the block is pulling it low. Overflow periods are at least six cycles, which keeps the one-cycle wait for the released line shorter than a pulse spacing. The selector is changed only while the master is idle.

// File: rtl/smb_scl_pkg.sv
package smb_scl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_t;

  // number of bits to count 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // true when the tick now arriving completes a phase of lim ticks
  function automatic logic phase_done(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

  // bit period in overflow pulses for an unstretched bus
  function automatic int unsigned bit_pulses(input int unsigned lo, input int unsigned hi);
    return lo + hi;
  endfunction

endpackage

// File: rtl/smb_tick_sel.sv
module smb_tick_sel #(
  parameter int SEL_W = 2,
  localparam int NSRC = 1 << SEL_W
) (
  input  logic [NSRC-1:0]  ovf_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             gate_i,
  output logic             tick_o
);

  logic [NSRC-1:0] hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
    assign hit[g] = ovf_i[g] & (sel_i == IDX);
  end

  assign tick_o = gate_i & (|hit);

endmodule

// File: rtl/smb_scl_phase.sv
module smb_scl_phase
  import smb_scl_pkg::*;
#(
  parameter int LOW_TICKS  = 2,
  parameter int HIGH_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic tick_i,
  input  logic line_hi_i,
  output logic drive_low_o,
  output logic bit_tick_o
);

  localparam int MAXT = (LOW_TICKS > HIGH_TICKS) ? LOW_TICKS : HIGH_TICKS;
  localparam int CW   = cnt_width(MAXT);

  scl_phase_t      ph_q, ph_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            edge_d;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    edge_d = 1'b0;
    if (!active_i) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          ph_d   = PH_LOW;
          cnt_d  = '0;
          edge_d = 1'b1;
        end
        PH_LOW: begin
          if (tick_i) begin
            if (phase_done(int'(cnt_q), LOW_TICKS)) begin
              ph_d  = PH_WAIT;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        PH_WAIT: begin
          if (line_hi_i) begin
            ph_d   = PH_HIGH;
            cnt_d  = '0;
            edge_d = 1'b1;
          end
        end
        PH_HIGH: begin
          if (tick_i) begin
            if (phase_done(int'(cnt_q), HIGH_TICKS)) begin
              ph_d   = PH_LOW;
              cnt_d  = '0;
              edge_d = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      cnt_q      <= '0;
      bit_tick_o <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      cnt_q      <= cnt_d;
      bit_tick_o <= edge_d;
    end
  end

  assign drive_low_o = (ph_q == PH_LOW);

endmodule

// File: rtl/smb_slave_gate.sv
module smb_slave_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_en_i,
  input  logic inh_req_i,
  input  logic start_i,
  output logic slave_en_o,
  output logic force_nack_o
);

  logic inh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_q <= 1'b0;
    end else if (!bus_en_i || start_i) begin
      inh_q <= inh_req_i;
    end
  end

  assign slave_en_o   = bus_en_i & ~inh_q;
  assign force_nack_o = bus_en_i &  inh_q;

endmodule

// File: rtl/smb_scl_timer.sv
module smb_scl_timer #(
  parameter int SEL_W      = 2,
  parameter int LOW_TICKS  = 2,
  parameter int HIGH_TICKS = 1,
  localparam int NSRC      = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  ovf_i,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             bus_en,
  input  logic             slv_inhibit,
  input  logic             mst_req,
  input  logic             tmo_en,
  input  logic             scl_in,
  input  logic             start_det,
  output logic             scl_drive_low,
  output logic             bit_tick,
  output logic             tmr_tick,
  output logic             slave_en,
  output logic             force_nack
);

  logic tick_gate;
  logic mst_active;

  assign tick_gate  = bus_en & (mst_req | tmo_en);
  assign mst_active = bus_en & mst_req;

  smb_tick_sel #(.SEL_W(SEL_W)) u_sel (
    .ovf_i  (ovf_i),
    .sel_i  (src_sel),
    .gate_i (tick_gate),
    .tick_o (tmr_tick)
  );

  smb_scl_phase #(
    .LOW_TICKS  (LOW_TICKS),
    .HIGH_TICKS (HIGH_TICKS)
  ) u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (mst_active),
    .tick_i      (tmr_tick),
    .line_hi_i   (scl_in),
    .drive_low_o (scl_drive_low),
    .bit_tick_o  (bit_tick)
  );

  smb_slave_gate u_slv (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_en_i     (bus_en),
    .inh_req_i    (slv_inhibit),
    .start_i      (start_det),
    .slave_en_o   (slave_en),
    .force_nack_o (force_nack)
  );

endmodule

// File: rtl/smb_scl_timer_chk.sv
module smb_scl_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_en,
  input logic mst_req,
  input logic tmo_en,
  input logic scl_in,
  input logic start_det,
  input logic scl_drive_low,
  input logic bit_tick,
  input logic tmr_tick,
  input logic force_nack
);

  a_r2_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_en || !(mst_req || tmo_en)) |-> !tmr_tick);

  a_r3_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_drive_low) |-> ($past(tmr_tick) || !$past(bus_en && mst_req)));

  a_r5_fall_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> bit_tick);

  a_r5_rise_after_line: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !scl_drive_low) |-> $past(scl_in));

  a_r6_off_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_en) |-> (!scl_drive_low && !bit_tick));

  a_r7_hold_until_start: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && $past(bus_en) && !$past(start_det)) |-> $stable(force_nack));

  a_r10_release_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mst_req) |-> !scl_drive_low);

endmodule

bind smb_scl_timer smb_scl_timer_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_en        (bus_en),
  .mst_req       (mst_req),
  .tmo_en        (tmo_en),
  .scl_in        (scl_in),
  .start_det     (start_det),
  .scl_drive_low (scl_drive_low),
  .bit_tick      (bit_tick),
  .tmr_tick      (tmr_tick),
  .force_nack    (force_nack)
);

// File: tb/test_smb_scl_timer.sv
`timescale 1ns/1ps
module test_smb_scl_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ovf_i = '0;
  logic [1:0] src_sel = '0;
  logic       bus_en = 1'b0, slv_inhibit = 1'b0, mst_req = 1'b0, tmo_en = 1'b0;
  logic       start_det = 1'b0, stretch = 1'b0;
  logic       scl_in;
  logic       scl_drive_low, bit_tick, tmr_tick, slave_en, force_nack;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  int per [4] = '{6, 8, 10, 12};
  int oc  [4] = '{0, 0, 0, 0};

  always #5 clk = ~clk;

  assign scl_in = !scl_drive_low && !stretch;

  smb_scl_timer i_smb_scl_timer (
    .clk(clk), .rst_n(rst_n), .ovf_i(ovf_i), .src_sel(src_sel),
    .bus_en(bus_en), .slv_inhibit(slv_inhibit), .mst_req(mst_req),
    .tmo_en(tmo_en), .scl_in(scl_in), .start_det(start_det),
    .scl_drive_low(scl_drive_low), .bit_tick(bit_tick), .tmr_tick(tmr_tick),
    .slave_en(slave_en), .force_nack(force_nack)
  );

  always @(negedge clk) begin
    for (int j = 0; j < 4; j++) begin
      if (oc[j] == per[j] - 1) begin
        oc[j] <= 0;
        ovf_i[j] <= 1'b1;
      end else begin
        oc[j] <= oc[j] + 1;
        ovf_i[j] <= 1'b0;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #3;
  endtask

  // wait until drive equals v; count cycles and strobes seen on the way
  task automatic wait_drive(input logic v, output int ncyc, output int nbt);
    ncyc = 0;
    nbt = 0;
    do begin
      step();
      ncyc++;
      if (bit_tick) nbt++;
    end while (scl_drive_low !== v);
  endtask

  task automatic align_fall();
    int a, b;
    wait_drive(1'b1, a, b);
    wait_drive(1'b0, a, b);
    wait_drive(1'b1, a, b);
  endtask

  initial begin
    int lo, hi, bt1, bt2, ok_cnt, seen;
    // R11: reset state
    repeat (3) begin
      step();
      chk(!scl_drive_low && !bit_tick, "R11", scl_drive_low, 0);
    end
    rst_n = 1'b1;
    step();
    chk(!scl_drive_low && !bit_tick && !slave_en && !force_nack, "R11", scl_drive_low, 0);

    // R6: bus disabled, everything quiet
    mst_req = 1'b1; tmo_en = 1'b1;
    ok_cnt = 0;
    repeat (30) begin
      step();
      if (!scl_drive_low && !bit_tick && !tmr_tick && !slave_en && !force_nack) ok_cnt++;
    end
    chk(ok_cnt == 30, "R6", ok_cnt, 30);
    mst_req = 1'b0; tmo_en = 1'b0;

    // R2: gate closed with bus enabled
    bus_en = 1'b1;
    ok_cnt = 0;
    repeat (40) begin
      step();
      if (!tmr_tick && !scl_drive_low) ok_cnt++;
    end
    chk(ok_cnt == 40, "R2", ok_cnt, 40);

    // R1: selection sweep through timeout gate, SCL not driven
    tmo_en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      src_sel = 2'(s);
      ok_cnt = 0;
      seen = 0;
      repeat (30) begin
        step();
        if (tmr_tick === ovf_i[s] && !scl_drive_low) ok_cnt++;
        if (tmr_tick) seen++;
      end
      chk(ok_cnt == 30 && seen > 0, "R1", ok_cnt, 30);
    end
    tmo_en = 1'b0;

    // R3 R4 R5: timing per selected source
    for (int s = 0; s < 4; s++) begin
      src_sel = 2'(s);
      mst_req = 1'b1;
      align_fall();
      for (int k = 0; k < 2; k++) begin
        wait_drive(1'b0, lo, bt1);
        wait_drive(1'b1, hi, bt2);
        chk(lo == 2 * per[s], "R3", lo, 2 * per[s]);
        chk(lo + hi == 3 * per[s], "R4", lo + hi, 3 * per[s]);
        chk(bt1 + bt2 == 2, "R5", bt1 + bt2, 2);
      end
      mst_req = 1'b0;
      step();
      chk(!scl_drive_low, "R10", scl_drive_low, 0);
      repeat (5) step();
    end

    // R10: drop request in mid low phase
    src_sel = 2'd1;
    mst_req = 1'b1;
    align_fall();
    repeat (3) step();
    chk(scl_drive_low, "R10", scl_drive_low, 1);
    mst_req = 1'b0;
    step();
    chk(!scl_drive_low, "R10", scl_drive_low, 0);
    repeat (4) step();

    // R9: stretching
    src_sel = 2'd0;
    mst_req = 1'b1;
    align_fall();
    wait_drive(1'b0, lo, bt1);
    stretch = 1'b1;
    ok_cnt = 0;
    repeat (25) begin
      step();
      if (!scl_drive_low && !bit_tick) ok_cnt++;
    end
    chk(ok_cnt == 25, "R9", ok_cnt, 25);
    stretch = 1'b0;
    step();
    chk(bit_tick && !scl_drive_low, "R9", bit_tick, 1);
    wait_drive(1'b1, hi, bt2);
    chk(hi >= 1 && hi <= per[0] + 1, "R9", hi, per[0]);
    mst_req = 1'b0;
    repeat (3) step();

    // R7 R8: inhibit latched at START
    slv_inhibit = 1'b0;
    start_det = 1'b1; step(); start_det = 1'b0; step();
    chk(slave_en && !force_nack, "R8", slave_en, 1);
    slv_inhibit = 1'b1;
    repeat (6) step();
    chk(slave_en && !force_nack, "R7", force_nack, 0);
    start_det = 1'b1; step(); start_det = 1'b0;
    chk(!slave_en && force_nack, "R8", force_nack, 1);
    slv_inhibit = 1'b0;
    repeat (6) step();
    chk(!slave_en && force_nack, "R7", force_nack, 1);
    start_det = 1'b1; step(); start_det = 1'b0;
    chk(slave_en && !force_nack, "R7", slave_en, 1);

    // R6: disabling clears both flags
    slv_inhibit = 1'b1;
    bus_en = 1'b0;
    step();
    chk(!slave_en && !force_nack, "R6", force_nack, 0);
    bus_en = 1'b1;
    step();
    chk(force_nack && !slave_en, "R8", force_nack, 1);

    finish_run();
  end

endmodule